// File: doc/BRIEF.md
# Extended-Page Opcode Decoder with Interrupt Control

This block sits in an 8-bit processor core behind the prefix logic. It receives the byte that follows the extended-page prefix. For the range 40h to 7Fh it produces an operation class, an operand register select, a register-pair select and a two-bit qualifier. The execution datapath uses these to steer port transfers, 16-bit carry arithmetic, absolute 16-bit loads and stores, accumulator negation, returns, I/R transfers and nibble rotations. Every byte outside that range decodes as a two-byte no-op. This includes the block-transfer codes, which another unit handles. The undocumented mirror codes decode in full, as their hardware behaviour defines them.

The block also owns the interrupt state: the two-bit interrupt mode and the two enable flip-flops. Mode-set codes update the mode. Every return code, the interrupt-return code included, copies the second enable flop into the first. Single-cycle request inputs cover enable, disable and non-maskable acceptance. A status output tells the interrupt sequencer when the vector is fixed at restart address 38h regardless of the bus byte.

The decode outputs are combinational from `op_valid` and `op_byte`. The interrupt state changes on the clock edge at which the code is presented.

Top module: `xpg_decoder`

## Requirements
- R1: While reset is asserted, and until the first qualified input after release, `iff1`, `iff2` and `int_mode` are all 0.
- R2: With `op_valid` high, every byte in 40h..7Fh whose low three bits are 100 decodes to class 5 (negate accumulator). All eight mirrors behave the same.
- R3: Every byte in 40h..7Fh with low bits 101 decodes to class 6 (return). After the edge it is presented on, `iff1` takes the prior value of `iff2` and `iff2` is unchanged. This holds unless an enable, disable or non-maskable request is present in the same cycle.
- R4: Low bits 110 decode to class 7 (mode set). Bits 4:3 of 00 or 01 load mode 0, 10 loads mode 1, and 11 loads mode 2. So 46h, 4Eh, 66h and 6Eh give mode 0; 56h and 76h give mode 1; 5Eh and 7Eh give mode 2. The mode changes on no other input and never reads 3.
- R5: Low bits 000 decode to class 1 (port input), with `reg_sel` set to bits 5:3 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A). For 70h, `op_qual` is 01, meaning flags only with no register write. Otherwise `op_qual` is 00.
- R6: Low bits 001 decode to class 2 (port output), with `reg_sel` set to bits 5:3. For 71h, `op_qual` is 01, meaning a constant zero is written. Otherwise `op_qual` is 00.
- R7: Low bits 010 decode to class 3 (16-bit carry arithmetic), with `pair_sel` set to bits 5:4 (0 BC, 1 DE, 2 HL, 3 SP). `op_qual` is 01 for subtract (bit 3 clear) and 00 for add.
- R8: Low bits 011 decode to class 4 (16-bit absolute transfer), with `pair_sel` set to bits 5:4. `op_qual` is 01 for a load from memory (bit 3 set) and 00 for a store. This makes 63h a store of HL and 6Bh a load of HL.
- R9: 47h, 4Fh, 57h and 5Fh decode to class 8 (I/R transfer), with `op_qual` = {bit 4 (to accumulator), bit 3 (R register)}. 67h and 6Fh decode to class 9 (nibble rotate), with `op_qual` = 01 for the left rotate 6Fh.
- R10: 77h, 7Fh and every byte outside 40h..7Fh decode to class 0 (no-op). They leave the interrupt state unchanged.
- R11: `di_req` clears both enable flops. Otherwise `ei_req` sets both. `nmi_take` then forces `iff1` to 0 and leaves `iff2` as it is.
- R12: `vector_fixed` is high exactly when `int_mode` is 1.
- R13: With `op_valid` low, all decode outputs are 0 and no code affects the interrupt state.
- R14: `reg_sel` is 0 for every class other than port input and output. `pair_sel` is 0 for every class other than 16-bit arithmetic and transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| op_valid | input | 1 | `op_byte` holds a byte that follows the extended-page prefix |
| op_byte | input | 8 | Second opcode byte |
| ei_req | input | 1 | Enable-interrupts request, one cycle |
| di_req | input | 1 | Disable-interrupts request, one cycle |
| nmi_take | input | 1 | Non-maskable interrupt accepted, one cycle |
| op_class | output | 4 | Operation class code |
| reg_sel | output | 3 | 8-bit operand register select |
| pair_sel | output | 2 | 16-bit register pair select |
| op_qual | output | 2 | Class-specific qualifier |
| int_mode | output | 2 | Current interrupt mode |
| iff1 | output | 1 | Interrupt enable flop 1 |
| iff2 | output | 1 | Interrupt enable flop 2 |
| vector_fixed | output | 1 | Interrupt vector fixed at restart 38h |

## Verification
The assertions take for granted that the inputs carry known 0/1 values and change only between clock edges. They also assume that request inputs are sampled together with any return code on the same edge. The return assertion is guarded so that it applies only when no request is present. The stimulus drives every input on the falling edge. It sweeps all 256 second-byte values and then runs a random mix in which requests coincide with returns and mode sets. The priority paths are therefore exercised rather than excluded.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
  localparam int OP_W   = 8;
  localparam int SEL_W  = 3;
  localparam int PAIR_W = 2;
  localparam int QUAL_W = 2;
  localparam int MODE_W = 2;
  localparam int CLS_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_NOP   = 4'd0,
    CL_PIN   = 4'd1,
    CL_POUT  = 4'd2,
    CL_ARI16 = 4'd3,
    CL_LD16  = 4'd4,
    CL_NEG   = 4'd5,
    CL_RET   = 4'd6,
    CL_SETIM = 4'd7,
    CL_IRX   = 4'd8,
    CL_DROT  = 4'd9
  } op_class_e;
endpackage

// File: rtl/xpg_rst_sync.sv
module xpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/xpg_opdec.sv
module xpg_opdec
  import xpg_pkg::*;
(
  input  logic              valid,
  input  logic [OP_W-1:0]   opb,
  output op_class_e         cls,
  output logic [SEL_W-1:0]  rsel,
  output logic [PAIR_W-1:0] psel,
  output logic [QUAL_W-1:0] qual,
  output logic [MODE_W-1:0] im_val
);
  logic       in_page;
  logic [2:0] low3;
  logic [2:0] mid3;

  assign in_page = valid && (opb[7:6] == 2'b01);
  assign low3    = opb[2:0];
  assign mid3    = opb[5:3];

  always_comb begin
    cls    = CL_NOP;
    rsel   = '0;
    psel   = '0;
    qual   = '0;
    im_val = '0;
    if (in_page) begin
      unique case (low3)
        3'd0: begin
          cls  = CL_PIN;
          rsel = mid3;
          qual = {1'b0, mid3 == 3'd6};
        end
        3'd1: begin
          cls  = CL_POUT;
          rsel = mid3;
          qual = {1'b0, mid3 == 3'd6};
        end
        3'd2: begin
          cls  = CL_ARI16;
          psel = mid3[2:1];
          qual = {1'b0, ~mid3[0]};
        end
        3'd3: begin
          cls  = CL_LD16;
          psel = mid3[2:1];
          qual = {1'b0, mid3[0]};
        end
        3'd4: cls = CL_NEG;
        3'd5: cls = CL_RET;
        3'd6: begin
          cls    = CL_SETIM;
          im_val = mid3[1] ? (mid3[0] ? 2'd2 : 2'd1) : 2'd0;
        end
        3'd7: begin
          if (!mid3[2]) begin
            cls  = CL_IRX;
            qual = mid3[1:0];
          end else if (!mid3[1]) begin
            cls  = CL_DROT;
            qual = {1'b0, mid3[0]};
          end
        end
        default: cls = CL_NOP;
      endcase
    end
  end
endmodule

// File: rtl/xpg_iff_ctrl.sv
module xpg_iff_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_go,
  input  logic ei,
  input  logic di,
  input  logic nmi,
  output logic iff1_q,
  output logic iff2_q
);
  logic iff1_d;
  logic iff2_d;

  always_comb begin
    iff1_d = iff1_q;
    iff2_d = iff2_q;
    if (di) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (ei) begin
      iff1_d = 1'b1;
      iff2_d = 1'b1;
    end else if (ret_go) begin
      iff1_d = iff2_q;
    end
    if (nmi) iff1_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else begin
      iff1_q <= iff1_d;
      iff2_q <= iff2_d;
    end
  end

  // R3: a return restores flop 1 from flop 2 and keeps flop 2
  a_r3_ret_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_go && !ei && !di && !nmi) |=> (iff1_q == $past(iff2_q)) && $stable(iff2_q));
  // R11: non-maskable acceptance clears flop 1 only
  a_r11_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !ei && !di) |=> !iff1_q && $stable(iff2_q));
  // R11: disable wins over enable
  a_r11_di_clear: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> !iff1_q && !iff2_q);
  a_r11_ei_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ei && !di && !nmi) |=> iff1_q && iff2_q);
endmodule

// File: rtl/xpg_imode_reg.sv
module xpg_imode_reg
  import xpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_go,
  input  logic [MODE_W-1:0] set_val,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (set_go) mode_d = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  // R4: mode 3 is never reached
  a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);
  // R4: mode holds without a mode-set code
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_go |=> $stable(mode_q));
endmodule

// File: rtl/xpg_decoder.sv
module xpg_decoder
  import xpg_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_byte,
  input  logic              ei_req,
  input  logic              di_req,
  input  logic              nmi_take,
  output logic [CLS_W-1:0]  op_class,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [PAIR_W-1:0] pair_sel,
  output logic [QUAL_W-1:0] op_qual,
  output logic [MODE_W-1:0] int_mode,
  output logic              iff1,
  output logic              iff2,
  output logic              vector_fixed
);
  logic              rst_sync_n;
  op_class_e         cls;
  logic [MODE_W-1:0] im_val;
  logic              ret_go;
  logic              set_go;

  xpg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xpg_opdec u_dec (
    .valid(op_valid), .opb(op_byte), .cls(cls), .rsel(reg_sel),
    .psel(pair_sel), .qual(op_qual), .im_val(im_val)
  );

  assign ret_go = (cls == CL_RET);
  assign set_go = (cls == CL_SETIM);

  xpg_iff_ctrl u_iff (
    .clk(clk), .rst_n(rst_sync_n), .ret_go(ret_go), .ei(ei_req),
    .di(di_req), .nmi(nmi_take), .iff1_q(iff1), .iff2_q(iff2)
  );

  xpg_imode_reg u_mode (
    .clk(clk), .rst_n(rst_sync_n), .set_go(set_go), .set_val(im_val),
    .mode_q(int_mode)
  );

  assign op_class     = cls;
  assign vector_fixed = (int_mode == 2'd1);

  // R13: nothing decodes while no byte is presented
  a_r13_idle_nop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |-> (op_class == 4'd0) && (reg_sel == '0) && (op_qual == '0));
  // R14: register selects stay at zero outside their classes
  a_r14_sel_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_class != 4'd1 && op_class != 4'd2) |-> reg_sel == '0);
  // R10: bytes outside the page leave the interrupt state alone
  a_r10_outside_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_byte[7:6] != 2'b01 && !ei_req && !di_req && !nmi_take)
      |=> $stable(iff1) && $stable(iff2) && $stable(int_mode));
endmodule

// File: tb/xpg_decoder_tb.sv
module xpg_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic       ei_req = 1'b0, di_req = 1'b0, nmi_take = 1'b0;
  logic [3:0] op_class;
  logic [2:0] reg_sel;
  logic [1:0] pair_sel, op_qual, int_mode;
  logic       iff1, iff2, vector_fixed;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  int m_iff1 = 0, m_iff2 = 0, m_mode = 0;

  always #2.5 clk = ~clk;

  xpg_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .ei_req(ei_req), .di_req(di_req), .nmi_take(nmi_take),
    .op_class(op_class), .reg_sel(reg_sel), .pair_sel(pair_sel),
    .op_qual(op_qual), .int_mode(int_mode), .iff1(iff1), .iff2(iff2),
    .vector_fixed(vector_fixed)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void ref_dec(input bit v, input int b, output int cls,
                                  output int rs, output int ps, output int q,
                                  output int im);
    int lo, r;
    cls = 0; rs = 0; ps = 0; q = 0; im = 0;
    lo = b % 8;
    r  = (b / 8) % 8;
    if (v && b >= 64 && b < 128) begin
      case (lo)
        0: begin cls = 1; rs = r; q = (r == 6) ? 1 : 0; end
        1: begin cls = 2; rs = r; q = (r == 6) ? 1 : 0; end
        2: begin cls = 3; ps = r / 2; q = (r % 2 == 0) ? 1 : 0; end
        3: begin cls = 4; ps = r / 2; q = r % 2; end
        4: cls = 5;
        5: cls = 6;
        6: begin cls = 7; im = (r % 4 < 2) ? 0 : ((r % 4 == 2) ? 1 : 2); end
        default: begin
          if (r < 4) begin cls = 8; q = r; end
          else if (r < 6) begin cls = 9; q = r - 4; end
        end
      endcase
    end
  endfunction

  function automatic string tag_of(input bit v, input int cls);
    if (!v) return "R13";
    case (cls)
      1: return "R5";  2: return "R6";  3: return "R7";  4: return "R8";
      5: return "R2";  6: return "R3";  7: return "R4";  8, 9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_state(input string req);
    chk(req, "iff1", int'(iff1), m_iff1);
    chk(req, "iff2", int'(iff2), m_iff2);
    chk(req, "int_mode", int'(int_mode), m_mode);
    chk("R12", "vector_fixed", int'(vector_fixed), (m_mode == 1) ? 1 : 0);
  endtask

  task automatic step(input bit v, input int b, input bit e, input bit d,
                      input bit n, input string sreq);
    int cls, rs, ps, q, im;
    string t;
    @(negedge clk);
    op_valid = v; op_byte = 8'(b); ei_req = e; di_req = d; nmi_take = n;
    #1;
    ref_dec(v, b, cls, rs, ps, q, im);
    t = tag_of(v, cls);
    chk(t, "op_class", int'(op_class), cls);
    chk(t, "reg_sel", int'(reg_sel), rs);
    chk(t, "pair_sel", int'(pair_sel), ps);
    chk(t, "op_qual", int'(op_qual), q);
    if (cls != 1 && cls != 2) chk("R14", "reg_sel_zero", int'(reg_sel), 0);
    if (cls != 3 && cls != 4) chk("R14", "pair_sel_zero", int'(pair_sel), 0);
    @(posedge clk);
    begin
      int n1, n2;
      n1 = m_iff1; n2 = m_iff2;
      if (d) begin n1 = 0; n2 = 0; end
      else if (e) begin n1 = 1; n2 = 1; end
      else if (cls == 6) n1 = m_iff2;
      if (n) n1 = 0;
      m_iff1 = n1; m_iff2 = n2;
      if (cls == 7) m_mode = im;
    end
    #1;
    check_state(sreq);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_state("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_state("R1");

    // R11: enable, then returns must keep both set
    step(1'b0, 0, 1'b1, 1'b0, 1'b0, "R11");
    step(1'b1, 8'h4D, 1'b0, 1'b0, 1'b0, "R3");
    // R11: non-maskable clears flop 1, return restores it from flop 2
    step(1'b0, 0, 1'b0, 1'b0, 1'b1, "R11");
    step(1'b1, 8'h7D, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 8'h45, 1'b0, 1'b1, 1'b0, "R11");
    step(1'b1, 8'h55, 1'b1, 1'b1, 1'b0, "R11");
    // R4: every mode-set mirror
    step(1'b1, 8'h56, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h6E, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h7E, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h76, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 8'h5E, 1'b0, 1'b0, 1'b0, "R13");
    step(1'b1, 8'h4E, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h5E, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'hA0, 1'b0, 1'b0, 1'b0, "R10");

    // full sweep of the second byte
    for (int b = 0; b < 256; b++) begin
      step(1'b1, b, (b % 37) == 3, (b % 53) == 7, (b % 29) == 11, "R11");
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int b;
      b = ($urandom_range(0, 3) != 0) ? int'($urandom_range(64, 127))
                                      : int'($urandom_range(0, 255));
      step($urandom_range(0, 3) != 0, b, $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0, "R11");
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule